// File: doc/BRIEF.md
# Column-Compression Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. An AND array forms every partial-product bit at once. Each bit goes into the column that matches its weight. A reduction network then shrinks the columns, stage by stage, until each column holds at most two bits. A final carry-propagate adder sums the two remaining rows.

The reduction follows the Dadda height schedule. Every stage has a height limit, and a column is compressed only by the amount that brings it down to that limit. Full adders (3-to-2 counters) and half adders (2-to-2 counters) are the only cells. Each full adder is built from two XNORs and a 2:1 multiplexer rather than the usual XOR/AND/OR form.

A parameter selects a single output register, so the block can sit between flops for timing analysis. With the register removed, the block is purely combinational.

Top module: `dadda_mult`

## Requirements
- R1: For every pair of unsigned operands, `product` equals the arithmetic product a*b over the full 2N bits. The default N is 8, and any N from 2 to 64 is accepted.
- R2: The partial-product bit a[j]&b[i] carries weight i+j. If either operand is zero, the product is zero.
- R3: Every full adder computes t = XNOR(x,y), sum = XNOR(t,cin) and carry = (t ? x : cin). Its carry and sum together equal the count of ones among x, y and cin.
- R4: The stage limits come from d1=2 and d(k+1)=floor(1.5*d(k)). Reduction starts at the largest limit below N and steps down to 2, so for N=8 the limits are 6, 4, 3 and 2.
- R5: Within a stage, a column whose height (including carries arriving from the column below) exceeds the limit by e gets floor(e/2) full adders and (e mod 2) half adders. A column within the limit is left alone.
- R6: After the last stage, every column holds at most two bits. The two rows sum to a*b with no carry beyond bit 2N-1.
- R7: The product MSB is formed from the carry out of the final adder, which spans columns 0 to 2N-2. For N=8, 255*255 gives 0xFE01 with the MSB set, and 128*128 gives 0x4000 with the MSB clear.
- R8: With `REG_OUT`=1, the product of the operands present at a rising clock edge appears on `product` after that edge. While `rst_n` is low, `product` is zero.
- R9: A multiplier of one returns the multiplicand unchanged, and a multiplicand of one returns the multiplier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low clear of the output register |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| product | output | 2N | Unsigned product, registered when REG_OUT=1 |

## Verification
The output register's clear and the capture of a fresh product can fall in the same cycle. To provoke this, new operands are applied in the very cycle that `rst_n` is pulled low. The result is judged correct only if zero is seen there, and the product of those same operands then appears exactly one cycle after release. The all-ones pair is applied next to the reset sequence, so the full carry ripple through the final adder is judged in the same cycle range.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

  // Number of reduction stages: how many schedule limits lie below n.
  function automatic int stage_count(input int n);
    int d;
    int cnt;
    d = 2;
    cnt = 0;
    while (d < n) begin
      cnt = cnt + 1;
      d = (d * 3) / 2;
    end
    return cnt;
  endfunction

  // Height limit applied in stage s (s = 0 is the first, tallest stage).
  function automatic int stage_limit(input int n, input int s);
    int d;
    int t;
    t = stage_count(n) - 1 - s;
    d = 2;
    for (int i = 0; i < t; i++) d = (d * 3) / 2;
    return d;
  endfunction

  // Height of column c of the raw partial-product matrix.
  function automatic int init_height(input int n, input int c);
    if (c < n) return c + 1;
    if (c < 2 * n - 1) return 2 * n - 1 - c;
    return 0;
  endfunction

  // Lowest multiplier index that lands in column c.
  function automatic int col_base(input int n, input int c);
    return (c > n - 1) ? (c - n + 1) : 0;
  endfunction

  // Compact full adder: two XNORs and a multiplexer.
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    logic t;
    t = ~(x ^ y);
    return ~(t ^ ci);
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    logic t;
    t = ~(x ^ y);
    return t ? x : ci;
  endfunction

  function automatic logic ha_sum(input logic x, input logic y);
    return x ^ y;
  endfunction

  function automatic logic ha_carry(input logic x, input logic y);
    return x & y;
  endfunction

endpackage

// File: rtl/dadda_ppgen.sv
module dadda_ppgen #(
  parameter int N = 8,
  localparam int W = 2 * N
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] cols [W]
);
  import dadda_pkg::*;

  int col_idx;
  int base;

  always_comb begin
    col_idx = 0;
    base = 0;
    for (int c = 0; c < W; c++) cols[c] = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        col_idx = i + j;
        base = col_base(N, col_idx);
        cols[col_idx][i - base] = a[j] & b[i];
      end
    end
  end

  // Total number of ones in the matrix must equal ones(a) * ones(b).
  int ones_total;
  always_comb begin
    ones_total = 0;
    for (int c = 0; c < W; c++) ones_total = ones_total + $countones(cols[c]);
    if (!$isunknown({a, b})) begin
      AST_PP_POPULATION: assert (ones_total == $countones(a) * $countones(b)); // R2
    end
  end

endmodule

// File: rtl/dadda_reduce.sv
module dadda_reduce #(
  parameter int N = 8,
  localparam int W = 2 * N,
  localparam int STAGES = dadda_pkg::stage_count(N)
) (
  input  logic [N-1:0] cols [W],
  output logic [W-1:0] row_a,
  output logic [W-1:0] row_b
);
  import dadda_pkg::*;

  logic [N-1:0] cur  [W];
  logic [N-1:0] nxt  [W];
  int           hcur [W];
  int           hnxt [W];
  logic [N-1:0] cprev;
  logic [N-1:0] cnew;
  int           nprev;
  int           lim;
  int           excess;
  int           nfa;
  int           nha;
  int           wr;
  int           rd;
  logic         x, y, z, s_bit, c_bit;

  always_comb begin
    cprev = '0; cnew = '0; nprev = 0; lim = 0; excess = 0;
    nfa = 0; nha = 0; wr = 0; rd = 0;
    x = 1'b0; y = 1'b0; z = 1'b0; s_bit = 1'b0; c_bit = 1'b0;
    for (int c = 0; c < W; c++) begin
      cur[c]  = cols[c];
      nxt[c]  = '0;
      hcur[c] = init_height(N, c);
      hnxt[c] = 0;
    end

    for (int s = 0; s < STAGES; s++) begin
      lim   = stage_limit(N, s);
      nprev = 0;
      cprev = '0;
      for (int c = 0; c < W; c++) begin
        nxt[c] = '0;
        cnew   = '0;
        wr     = 0;
        rd     = 0;
        excess = hcur[c] + nprev - lim;
        if (excess < 0) excess = 0;
        nfa = excess / 2;
        nha = excess % 2;

        // full adders consume three bits, leave a sum here, a carry above
        for (int f = 0; f < N; f++) begin
          if (f < nfa) begin
            x = cur[c][rd];
            y = cur[c][rd + 1];
            z = cur[c][rd + 2];
            s_bit = fa_sum(x, y, z);
            c_bit = fa_carry(x, y, z);
            if (!$isunknown({x, y, z})) begin
              AST_FA_COUNT: assert ({c_bit, s_bit} == 2'(x) + 2'(y) + 2'(z)); // R3
            end
            nxt[c][wr] = s_bit;
            cnew[f]    = c_bit;
            rd = rd + 3;
            wr = wr + 1;
          end
        end

        // at most one half adder per column and stage
        if (nha != 0) begin
          nxt[c][wr] = ha_sum(cur[c][rd], cur[c][rd + 1]);
          cnew[nfa]  = ha_carry(cur[c][rd], cur[c][rd + 1]);
          rd = rd + 2;
          wr = wr + 1;
        end

        // untouched bits pass straight through
        for (int q = 0; q < N; q++) begin
          if (q >= rd && q < hcur[c]) begin
            nxt[c][wr] = cur[c][q];
            wr = wr + 1;
          end
        end

        // carries produced by the column below in this stage
        for (int q = 0; q < N; q++) begin
          if (q < nprev) begin
            nxt[c][wr] = cprev[q];
            wr = wr + 1;
          end
        end

        hnxt[c] = wr;
        cprev   = cnew;
        nprev   = nfa + nha;
      end

      for (int c = 0; c < W; c++) begin
        cur[c]  = nxt[c];
        hcur[c] = hnxt[c];
      end
    end

    for (int c = 0; c < W; c++) begin
      row_a[c] = cur[c][0];
      row_b[c] = cur[c][1];
    end
  end

endmodule

// File: rtl/dadda_cpa.sv
module dadda_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  output logic [W-1:0] sum,
  output logic         carry_top
);

  wire [W-1:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W - 1; i++) begin : g_bit
    logic p_i, g_i;
    assign p_i = op_x[i] ^ op_y[i];
    assign g_i = op_x[i] & op_y[i];
    assign sum[i] = p_i ^ chain[i];
    assign chain[i + 1] = g_i | (p_i & chain[i]);
  end

  assign carry_top  = chain[W-1];
  assign sum[W-1]   = op_x[W-1] ^ op_y[W-1] ^ carry_top;

  // Rows from the tree never produce a value beyond 2N bits.
  logic [W:0] wide_sum;
  always_comb begin
    wide_sum = {1'b0, op_x} + {1'b0, op_y};
    if (!$isunknown({op_x, op_y})) begin
      AST_NO_OVERFLOW: assert (!wide_sum[W]); // R6
    end
  end

endmodule

// File: rtl/dadda_mult.sv
module dadda_mult #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int W      = 2 * N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [W-1:0] product
);

  logic [N-1:0] pp_cols [W];
  logic [W-1:0] row_a;
  logic [W-1:0] row_b;
  logic [W-1:0] prod_comb;
  logic         carry_top;

  dadda_ppgen #(.N(N)) u_ppgen (
    .a    (a),
    .b    (b),
    .cols (pp_cols)
  );

  dadda_reduce #(.N(N)) u_reduce (
    .cols  (pp_cols),
    .row_a (row_a),
    .row_b (row_b)
  );

  dadda_cpa #(.W(W)) u_cpa (
    .op_x      (row_a),
    .op_y      (row_b),
    .sum       (prod_comb),
    .carry_top (carry_top)
  );

  if (REG_OUT) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= prod_comb;
    end
    assign product = q;

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (q == $past(prod_comb))); // R8
  end else begin : g_comb
    assign product = prod_comb;
  end

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    ((a == '0) || (b == '0)) |-> (prod_comb == '0)); // R2

  AST_UNIT_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (b == N'(1)) |-> (prod_comb == W'(a))); // R9

  AST_TWO_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_a + row_b) == (W'(a) * W'(b)))); // R6

  AST_MSB_FROM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_a[W-1] | row_b[W-1]) == 1'b0) |-> (prod_comb[W-1] == carry_top)); // R7

endmodule

// File: tb/dadda_mult_test.sv
module dadda_mult_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic [15:0] a16 = '0, b16 = '0;
  logic [31:0] p16;

  typedef struct {
    logic [15:0] e8;
    logic [31:0] e16;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dadda_mult #(.N(8), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .product(p8)
  );

  dadda_mult #(.N(16), .REG_OUT(1'b1)) uut_wide (
    .clk(clk), .rst_n(rst_n), .a(a16), .b(b16), .product(p16)
  );

  // Independent shift-and-add reference for the narrow instance.
  function automatic logic [15:0] ref_mul8(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] acc;
    acc = '0;
    for (int i = 0; i < 8; i++) if (y[i]) acc = acc + (16'(x) << i);
    return acc;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies operands at the falling edge, queues the expectation.
  task automatic drive(input bit rel, input logic [7:0] x, input logic [7:0] y,
                       input logic [15:0] wx, input logic [15:0] wy, input string tag);
    item_t it;
    @(negedge clk);
    rst_n = rel;
    a8 = x; b8 = y; a16 = wx; b16 = wy;
    it.e8  = rel ? ref_mul8(x, y) : 16'h0;
    it.e16 = rel ? (32'(wx) * 32'(wy)) : 32'h0;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: one result per cycle, a quarter period after the rising edge.
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD / 4);
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(it.tag, "narrow", 32'(p8), 32'(it.e8));
        check(it.tag, "wide", p16, it.e16);
      end
    end
  end

  initial begin
    // R8: reset state, operands already moving while cleared
    drive(1'b0, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, "R8");
    drive(1'b0, 8'h12, 8'h34, 16'h1234, 16'h5678, "R8");
    // R8: release with the same operands -> product one cycle later
    drive(1'b1, 8'h12, 8'h34, 16'h1234, 16'h5678, "R8");
    // R2: zero operands
    drive(1'b1, 8'h00, 8'hA7, 16'h0000, 16'hBEEF, "R2");
    drive(1'b1, 8'hC3, 8'h00, 16'h8001, 16'h0000, "R2");
    // R7: MSB from the final carry, set and clear
    drive(1'b1, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, "R7");
    drive(1'b1, 8'h80, 8'h80, 16'h8000, 16'h8000, "R7");
    // R9: unit operands
    drive(1'b1, 8'hD5, 8'h01, 16'hCAFE, 16'h0001, "R9");
    drive(1'b1, 8'h01, 8'h9B, 16'h0001, 16'h7A5C, "R9");
    // R3 / R4 / R5: dense and alternating patterns load the tallest columns
    drive(1'b1, 8'hFF, 8'hFE, 16'hFFFE, 16'hFFFF, "R3");
    drive(1'b1, 8'hAA, 8'h55, 16'hAAAA, 16'h5555, "R4");
    drive(1'b1, 8'h55, 8'hAA, 16'h5555, 16'hAAAA, "R5");
    drive(1'b1, 8'h7F, 8'hFF, 16'h7FFF, 16'hFFFF, "R6");
    // R8: reset pulse coinciding with a new pair, then recovery
    drive(1'b0, 8'hEE, 8'hDD, 16'hEEEE, 16'hDDDD, "R8");
    drive(1'b1, 8'hEE, 8'hDD, 16'hEEEE, 16'hDDDD, "R8");
    // R1: exhaustive narrow operands, random wide operands
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        drive(1'b1, 8'(i), 8'(j), 16'($urandom), 16'($urandom), "R1");
      end
    end
    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule